// File: doc/BRIEF.md
# Pulse-Swallow Feedback Counter Pair

This block is the low-speed counting stage of an integer-N PLL feedback divider. It runs on the output of an external dual-modulus prescaler, which divides the RF signal by either P or P+1. A 6-bit swallow counter selects the prescaler modulus, and a 13-bit main counter sets how many prescaler periods make up one division cycle. The first A prescaler periods of each cycle run at P+1 and the remaining B−A run at P. The feedback division is therefore N = B·P + A RF cycles, and the block emits one divided pulse per N RF cycles toward the phase detector.

The presets are captured on a load strobe and held until the current division cycle ends, so a cycle never mixes two settings. A swallow value larger than the main value is reported on a flag and clamped. Main values below 3 are raised to 3. Every N can be reached without gaps only when N ≥ P² − P. Below that bound the user must pick A and B with A ≤ B.

A controller with three named states sequences the counters:
- **ST_IDLE**: no valid preset yet.
- **ST_SWALLOW**: the modulus line is high.
- **ST_MAIN**: the modulus line is low.

The transitions are:
- **start**: ST_IDLE to ST_SWALLOW or ST_MAIN, when a captured preset exists.
- **swallow_done**: ST_SWALLOW to ST_MAIN, when the swallow counter reaches its last count.
- **wrap**: from either running state into the start state of the next cycle, when the main counter reaches its terminal count. The target state depends on whether the next swallow value is zero.

Top module: `swallow_div_top`

## Requirements
- R1: After rst_n is low, mod_ctl, div_pulse and a_invalid are 0, and the block stays idle, with no div_pulse and no mod_ctl, until a preset is loaded.
- R2: While running, consecutive rising edges of div_pulse are B prescaler periods apart. With a P/P+1 prescaler that is exactly B·P + A RF cycles.
- R3: mod_ctl is 1 during the first A prescaler periods of each division cycle and 0 for the rest of the cycle. Over one period it is high for A·(P+1) RF cycles. With A = 0 it is never high.
- R4: div_pulse is 1 for exactly one prescaler period, the last (B-th) period of each cycle. Its width in RF cycles is P, or P+1 when the effective A equals B.
- R5: If the active preset has A > B, a_invalid is 1 for as long as that preset is in use, and the counters use A = B, giving N = B·(P+1). A valid preset clears a_invalid.
- R6: A main preset below 3 is treated as 3.
- R7: a_in and b_in are captured on a clk edge with load = 1. They take effect only at the next division-cycle boundary, so the cycle in progress completes with the old values. From idle they take effect at the following edge. A later load before the boundary replaces an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Preset capture strobe |
| a_in | input | 6 | Swallow preset A |
| b_in | input | 13 | Main preset B |
| mod_ctl | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| div_pulse | output | 1 | Divided output pulse, one prescaler period wide |
| a_invalid | output | 1 | Active preset had A greater than B |

## Verification
The hardest case to reach is a preset change that arrives in the middle of a running division cycle. The bench has to show that the period enclosing the load still equals the old N and that only later periods take the new value. The bench drives a behavioural P/P+1 prescaler from the RF clock, waits for the falling edge of div_pulse, and then loads a new preset while the main counter still has many periods left. It then issues a second load before the boundary and checks that the later one wins.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_e;

    localparam int unsigned MAIN_FLOOR_DEFAULT = 3;

endpackage

// File: rtl/preset_hold.sv
module preset_hold #(
    parameter int unsigned A_W    = 6,
    parameter int unsigned B_W    = 13,
    parameter int unsigned B_MIN  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic           commit,
    output logic [A_W-1:0] a_eff,
    output logic [B_W-1:0] b_eff,
    output logic           pend_valid,
    output logic           a_bad
);
    localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);

    logic [A_W-1:0] pend_a, act_a, sel_a;
    logic [B_W-1:0] pend_b, act_b, sel_b, a_wide;
    logic           pend_q, bad_q, sel_bad;

    always_comb begin
        sel_a   = pend_q ? pend_a : act_a;
        sel_b   = pend_q ? pend_b : act_b;
        b_eff   = (sel_b < B_FLOOR) ? B_FLOOR : sel_b;
        a_wide  = B_W'(sel_a);
        sel_bad = (a_wide > b_eff);
        a_eff   = sel_bad ? b_eff[A_W-1:0] : sel_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_a <= '0;
            pend_b <= '0;
            act_a  <= '0;
            act_b  <= '0;
            pend_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (commit) begin
            act_a  <= sel_a;
            act_b  <= sel_b;
            bad_q  <= sel_bad;
            pend_q <= load;
            if (load) begin
                pend_a <= a_in;
                pend_b <= b_in;
            end
        end else if (load) begin
            pend_a <= a_in;
            pend_b <= b_in;
            pend_q <= 1'b1;
        end
    end

    assign pend_valid = pend_q;
    assign a_bad      = bad_q;

    // R7: active preset only moves on a cycle boundary
    assert_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_a) && $stable(act_b)));

endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr #(
    parameter int unsigned A_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reload,
    input  logic [A_W-1:0] a_val,
    output logic [A_W-1:0] a_cnt,
    output logic           a_last
);
    logic [A_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= a_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign a_cnt  = cnt_q;
    assign a_last = (cnt_q == A_W'(1));

endmodule

// File: rtl/main_ctr.sv
module main_ctr #(
    parameter int unsigned B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reload,
    input  logic           run,
    input  logic [B_W-1:0] b_val,
    output logic [B_W-1:0] b_cnt,
    output logic           b_term
);
    logic [B_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= b_val - 1'b1;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign b_cnt  = cnt_q;
    assign b_term = (cnt_q == '0);

    // R6: a reload never leaves fewer than three periods in the cycle
    assert_b_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q >= B_W'(2)));

endmodule

// File: rtl/swallow_div_top.sv
module swallow_div_top
    import swallow_div_pkg::*;
#(
    parameter int unsigned A_W   = 6,
    parameter int unsigned B_W   = 13,
    parameter int unsigned B_MIN = MAIN_FLOOR_DEFAULT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic           a_invalid
);
    localparam int unsigned CW = B_W + 1;

    div_state_e     state_q, state_d, start_st;
    logic [A_W-1:0] a_eff, a_cnt;
    logic [B_W-1:0] b_eff, b_cnt;
    logic           pend_valid, a_last, b_term, reload, running;

    preset_hold #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_preset (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .a_in       (a_in),
        .b_in       (b_in),
        .commit     (reload),
        .a_eff      (a_eff),
        .b_eff      (b_eff),
        .pend_valid (pend_valid),
        .a_bad      (a_invalid)
    );

    swallow_ctr #(.A_W(A_W)) u_swallow (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .a_val  (a_eff),
        .a_cnt  (a_cnt),
        .a_last (a_last)
    );

    main_ctr #(.B_W(B_W)) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .run    (running),
        .b_val  (b_eff),
        .b_cnt  (b_cnt),
        .b_term (b_term)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        start_st = (a_eff != '0) ? ST_SWALLOW : ST_MAIN;
        reload   = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_valid) begin
                    reload  = 1'b1;
                    state_d = start_st;
                end
            end
            ST_SWALLOW: begin
                if (b_term) begin
                    reload  = 1'b1;
                    state_d = start_st;
                end else if (a_last) begin
                    state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (b_term) begin
                    reload  = 1'b1;
                    state_d = start_st;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running   = (state_q != ST_IDLE);
        mod_ctl   = (state_q == ST_SWALLOW);
        div_pulse = running && b_term;
    end

    // R1: idle is silent
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!div_pulse && !mod_ctl));

    // R4: pulse lasts one prescaler period
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R3: once low, modulus control stays low until the wrap
    assert_mod_stays_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN && !div_pulse) |=> !mod_ctl);

    // R5: the swallow count never outlives the main count
    assert_swallow_within_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mod_ctl |-> (CW'(a_cnt) <= CW'(b_cnt) + CW'(1)));

endmodule

// File: tb/swallow_div_top_tb.sv
module swallow_div_top_tb;
    localparam int A_W      = 6;
    localparam int B_W      = 13;
    localparam int WD_LIMIT = 150000;
    // columns: P, A, B, expected N, expected mod-high RF cycles, pulse width, flag
    localparam int NV = 8;
    localparam int VEC [NV][7] = '{
        '{ 8,  5, 10,  85,  45,  8, 0},
        '{16,  0,  3,  48,   0, 16, 0},
        '{ 8, 63, 70, 623, 567,  8, 0},
        '{32,  7,  4, 132, 132, 33, 1},
        '{16, 17, 20, 337, 289, 16, 0},
        '{ 8,  1,  2,  25,   9,  8, 0},
        '{64,  3,  5, 323, 195, 64, 0},
        '{ 8,  3,  3,  27,  27,  9, 0}
    };

    logic           rf_clk = 1'b0;
    logic           pclk   = 1'b0;
    logic           rst_n  = 1'b0;
    logic           load   = 1'b0;
    logic [A_W-1:0] a_in   = '0;
    logic [B_W-1:0] b_in   = '0;
    logic           mod_ctl, div_pulse, a_invalid;

    int cur_p = 8;
    int pcnt  = 0;
    int checks = 0, errors = 0, cyc = 0;
    int rises = 0, last_period = 0, last_modhi = 0, last_width = 0;
    int cnt_rf = 0, cnt_mod = 0, cnt_w = 0;
    logic prev_div = 1'b0;
    logic done = 1'b0;

    always #10 rf_clk = ~rf_clk;

    swallow_div_top u_dut (
        .clk       (pclk),
        .rst_n     (rst_n),
        .load      (load),
        .a_in      (a_in),
        .b_in      (b_in),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse),
        .a_invalid (a_invalid)
    );

    // behavioural P/P+1 prescaler
    always @(posedge rf_clk) begin
        if (pcnt >= ((mod_ctl === 1'b1) ? cur_p + 1 : cur_p) - 1) begin
            pcnt <= 0;
            pclk <= 1'b1;
        end else begin
            pcnt <= pcnt + 1;
            if (pcnt + 1 >= cur_p / 2) pclk <= 1'b0;
        end
    end

    // period monitor, sampled away from the active edge
    always @(negedge rf_clk) begin
        if (div_pulse === 1'b1 && !prev_div) begin
            last_period = cnt_rf;
            last_modhi  = cnt_mod;
            rises++;
            cnt_rf  = 1;
            cnt_mod = (mod_ctl === 1'b1) ? 1 : 0;
            cnt_w   = 1;
        end else begin
            cnt_rf++;
            if (mod_ctl === 1'b1) cnt_mod++;
            if (div_pulse === 1'b1) cnt_w++;
            else if (prev_div) last_width = cnt_w;
        end
        prev_div = (div_pulse === 1'b1);
    end

    always @(posedge rf_clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rises(input int n);
        int target;
        target = rises + n;
        while (rises < target) @(negedge rf_clk);
    endtask

    task automatic program_preset(input int a, input int b);
        @(negedge pclk);
        load = 1'b1;
        a_in = A_W'(a);
        b_in = B_W'(b);
        @(negedge pclk);
        load = 1'b0;
    endtask

    task automatic wait_pulse_end();
        @(negedge rf_clk);
        while (div_pulse !== 1'b1) @(negedge rf_clk);
        while (div_pulse === 1'b1) @(negedge rf_clk);
    endtask

    initial begin
        int r0;
        repeat (40) @(posedge rf_clk);
        @(negedge rf_clk);
        check_int("R1 mod_ctl in reset", int'(mod_ctl), 0);
        check_int("R1 div_pulse in reset", int'(div_pulse), 0);
        check_int("R1 a_invalid in reset", int'(a_invalid), 0);
        rst_n = 1'b1;
        repeat (300) @(negedge rf_clk);
        check_int("R1 no pulse before load", rises, 0);
        check_int("R1 no modulus before load", int'(mod_ctl), 0);

        // table of vectors: R2 period, R3 modulus time, R4 width, R5/R6 clamps
        for (int i = 0; i < NV; i++) begin
            cur_p = VEC[i][0];
            program_preset(VEC[i][1], VEC[i][2]);
            wait_rises(4);
            check_int($sformatf("R2 period vec%0d", i), last_period, VEC[i][3]);
            check_int($sformatf("R3 mod-high vec%0d", i), last_modhi, VEC[i][4]);
            check_int($sformatf("R4 width vec%0d", i), last_width, VEC[i][5]);
            check_int($sformatf("R5 flag vec%0d", i), int'(a_invalid), VEC[i][6]);
        end

        // R7: mid-cycle load keeps the current cycle intact
        cur_p = 8;
        program_preset(5, 10);
        wait_rises(4);
        check_int("R2 period before change", last_period, 85);
        wait_pulse_end();
        program_preset(2, 20);
        wait_rises(1);
        check_int("R7 old period kept", last_period, 85);
        wait_rises(3);
        check_int("R7 new period applied", last_period, 162);

        // R7: a later load before the boundary replaces the earlier one
        wait_pulse_end();
        program_preset(1, 4);
        program_preset(6, 12);
        wait_rises(1);
        check_int("R7 old period kept again", last_period, 162);
        wait_rises(3);
        check_int("R7 last load wins", last_period, 102);
        check_int("R5 flag clear on valid preset", int'(a_invalid), 0);

        // R1: reset in the middle of a run
        @(negedge rf_clk);
        rst_n = 1'b0;
        repeat (40) @(negedge rf_clk);
        check_int("R1 mod_ctl after mid-run reset", int'(mod_ctl), 0);
        check_int("R1 div_pulse after mid-run reset", int'(div_pulse), 0);
        rst_n = 1'b1;
        r0 = rises;
        repeat (300) @(negedge rf_clk);
        check_int("R1 idle after mid-run reset", rises - r0, 0);
        program_preset(0, 5);
        wait_rises(4);
        check_int("R2 period after restart", last_period, 40);
        check_int("R3 no modulus with zero swallow", last_modhi, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule